// File: doc/BRIEF.md
# CCD Vertical Binning Line Sequencer

This block produces the two vertical transfer phases of a full-frame CCD. A line of charge moves from the last vertical line into the horizontal register when the second phase rises. The block also raises a hold request while it transfers, so that the horizontal clocks are parked with the first horizontal phase high and the second low. A programmable binning factor sets how many complete two-phase transfers are summed into the horizontal register before the serial readout of that register begins. When the factor is 1, each line is read out on its own.

A frame starts with a one-cycle start pulse. At that moment the block captures the row count, the binning factor and the three phase lengths. It then transfers the rows group by group. At the end of each group it pulses `line_ready` and reports the group's row count. It then waits for `hread_done` from the horizontal readout engine. If the last group has fewer rows left than the factor, it is transferred short. After the readout of the last group completes, `frame_done` pulses.

Top module: `vbin_line_seq`

## Requirements
- R1: After reset, `vclk1`, `vclk2`, `hpark`, `line_ready`, `frame_done` and `busy` are all 0, and they stay 0 until a frame is started.
- R2: Each high pulse of `vclk1` lasts exactly `ph1_len` cycles and each high pulse of `vclk2` lasts exactly `ph2_len` cycles. A length of 0 is treated as 1.
- R3: `vclk1` and `vclk2` are never high in the same cycle. Every fall of `vclk1` is followed by exactly `gap_len` cycles with both phases low before `vclk2` rises. Every fall of `vclk2` is followed by at least `gap_len` such cycles before `vclk1` rises again. A gap of 0 is treated as 1.
- R4: `hpark` is high in every cycle in which `vclk1` or `vclk2` is high.
- R5: Each group contains exactly min(effective factor, rows remaining) complete `vclk1`/`vclk2` sequences, counted as `vclk2` rising edges. `grp_rows` carries that count while `line_ready` is high.
- R6: A binning factor of 0 acts as 1, and any factor above 8 acts as 8.
- R7: The row count, binning factor and phase lengths are sampled only on the start pulse that begins a frame. Changing them during a frame has no effect on that frame. A start pulse that arrives while `busy` is high is ignored.
- R8: `line_ready` is a one-cycle pulse. It rises in the cycle after the gap that follows the group's last `vclk2` pulse. No vertical phase goes high after it until `hread_done` has been seen.
- R9: The frame has ceil(rows/factor) groups. `frame_done` pulses for one cycle, once, in the cycle after `hread_done` is accepted for the last group. With a row count of 0, it pulses two cycles after the start pulse and no group is produced.
- R10: When the row count is nonzero, `vclk1` first goes high in the second cycle after the cycle in which the start pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| row_count | input | ROW_W | Number of rows in the frame |
| bin_factor | input | BIN_W | Rows summed per horizontal load |
| ph1_len | input | PH_W | High time of `vclk1`, in cycles |
| ph2_len | input | PH_W | High time of `vclk2`, in cycles |
| gap_len | input | PH_W | Dead time between phases, in cycles |
| hread_done | input | 1 | Horizontal readout of the current group finished |
| vclk1 | output | 1 | Vertical phase 1 |
| vclk2 | output | 1 | Vertical phase 2; rising edge moves a line into the horizontal register |
| hpark | output | 1 | Request to hold the horizontal clocks in the parked transfer state |
| line_ready | output | 1 | One-cycle pulse: the group is loaded and ready for readout |
| grp_rows | output | BIN_W | Rows summed in the group just loaded |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at the end of the frame |

## Verification
The bench builds the block with its default parameters: 12-bit row counts, 8-bit phase lengths and a maximum factor of 8. The 4-bit factor input can therefore carry values above the maximum, as well as 0, and both clamps can be exercised. Short phase and gap lengths are used, including zeros, so the exact pulse widths and dead times can be measured edge by edge. Row counts are chosen to produce exact multiples, a short final group, a single full group of 8 and an empty frame.

// File: rtl/vbin_pkg.sv
package vbin_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PH1,
        ST_GAP1,
        ST_PH2,
        ST_GAP2,
        ST_READY,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

    // A programmed length of zero means one cycle
    function automatic logic [15:0] at_least_one(input logic [15:0] v);
        return (v == 16'd0) ? 16'd1 : v;
    endfunction

    // Binning factor clamp into 1..max
    function automatic logic [15:0] clamp_bin(input logic [15:0] v, input logic [15:0] vmax);
        logic [15:0] r;
        r = (v == 16'd0) ? 16'd1 : v;
        return (r > vmax) ? vmax : r;
    endfunction

endpackage

// File: rtl/vbin_cfg_latch.sv
module vbin_cfg_latch #(
    parameter int PH_W    = 8,
    parameter int BIN_W   = 4,
    parameter int BIN_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [BIN_W-1:0] bin_in,
    input  logic [PH_W-1:0]  ph1_in,
    input  logic [PH_W-1:0]  ph2_in,
    input  logic [PH_W-1:0]  gap_in,
    output logic [BIN_W-1:0] bin_q,
    output logic [PH_W-1:0]  ph1_q,
    output logic [PH_W-1:0]  ph2_q,
    output logic [PH_W-1:0]  gap_q
);
    import vbin_pkg::*;

    localparam logic [15:0] BMAX16 = 16'(BIN_MAX);

    logic [15:0] bin_n, ph1_n, ph2_n, gap_n;

    always_comb begin
        bin_n = clamp_bin(16'(bin_in), BMAX16);
        ph1_n = at_least_one(16'(ph1_in));
        ph2_n = at_least_one(16'(ph2_in));
        gap_n = at_least_one(16'(gap_in));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q <= BIN_W'(1);
            ph1_q <= PH_W'(1);
            ph2_q <= PH_W'(1);
            gap_q <= PH_W'(1);
        end else if (capture) begin
            bin_q <= bin_n[BIN_W-1:0];
            ph1_q <= ph1_n[PH_W-1:0];
            ph2_q <= ph2_n[PH_W-1:0];
            gap_q <= gap_n[PH_W-1:0];
        end
    end
endmodule

// File: rtl/vbin_phase_timer.sv
module vbin_phase_timer #(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [PH_W-1:0] len,
    output logic            last
);
    logic [PH_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - PH_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - PH_W'(1);
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/vbin_group_ctr.sv
module vbin_group_ctr #(
    parameter int ROW_W = 12,
    parameter int BIN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_load,
    input  logic [ROW_W-1:0] rows_in,
    input  logic [BIN_W-1:0] bin,
    input  logic             grp_start,
    input  logic             row_xfer,
    output logic             rows_empty,
    output logic             grp_full,
    output logic [BIN_W-1:0] grp_size
);
    logic [ROW_W-1:0] rows_left_q;
    logic [BIN_W-1:0] grp_cnt_q;
    logic [BIN_W-1:0] next_size;

    always_comb begin
        if (rows_left_q < ROW_W'(bin))
            next_size = rows_left_q[BIN_W-1:0];
        else
            next_size = bin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rows_left_q <= '0;
            grp_cnt_q   <= '0;
            grp_size    <= '0;
        end else begin
            if (frame_load)
                rows_left_q <= rows_in;
            else if (row_xfer)
                rows_left_q <= rows_left_q - ROW_W'(1);

            if (grp_start) begin
                grp_size  <= next_size;
                grp_cnt_q <= '0;
            end else if (row_xfer) begin
                grp_cnt_q <= grp_cnt_q + BIN_W'(1);
            end
        end
    end

    assign rows_empty = (rows_left_q == '0);
    assign grp_full   = (grp_cnt_q == grp_size);
endmodule

// File: rtl/vbin_line_seq.sv
module vbin_line_seq #(
    parameter int ROW_W   = 12,
    parameter int PH_W    = 8,
    parameter int BIN_MAX = 8,
    localparam int BIN_W  = $clog2(BIN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic [ROW_W-1:0] row_count,
    input  logic [BIN_W-1:0] bin_factor,
    input  logic [PH_W-1:0]  ph1_len,
    input  logic [PH_W-1:0]  ph2_len,
    input  logic [PH_W-1:0]  gap_len,
    input  logic             hread_done,
    output logic             vclk1,
    output logic             vclk2,
    output logic             hpark,
    output logic             line_ready,
    output logic [BIN_W-1:0] grp_rows,
    output logic             busy,
    output logic             frame_done
);
    import vbin_pkg::*;

    seq_state_t       state_q, state_d;
    logic             frame_load, grp_start, row_xfer;
    logic             t_load, t_last;
    logic [PH_W-1:0]  t_len;
    logic             rows_empty, grp_full;
    logic [BIN_W-1:0] bin_q;
    logic [PH_W-1:0]  ph1_q, ph2_q, gap_q;

    vbin_cfg_latch #(.PH_W(PH_W), .BIN_W(BIN_W), .BIN_MAX(BIN_MAX)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .capture (frame_load),
        .bin_in  (bin_factor),
        .ph1_in  (ph1_len),
        .ph2_in  (ph2_len),
        .gap_in  (gap_len),
        .bin_q   (bin_q),
        .ph1_q   (ph1_q),
        .ph2_q   (ph2_q),
        .gap_q   (gap_q)
    );

    vbin_group_ctr #(.ROW_W(ROW_W), .BIN_W(BIN_W)) u_grp (
        .clk        (clk),
        .rst        (rst),
        .frame_load (frame_load),
        .rows_in    (row_count),
        .bin        (bin_q),
        .grp_start  (grp_start),
        .row_xfer   (row_xfer),
        .rows_empty (rows_empty),
        .grp_full   (grp_full),
        .grp_size   (grp_rows)
    );

    vbin_phase_timer #(.PH_W(PH_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .len  (t_len),
        .last (t_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_start) state_d = ST_LOAD;
            ST_LOAD:  state_d = rows_empty ? ST_DONE : ST_PH1;
            ST_PH1:   if (t_last) state_d = ST_GAP1;
            ST_GAP1:  if (t_last) state_d = ST_PH2;
            ST_PH2:   if (t_last) state_d = ST_GAP2;
            ST_GAP2:  if (t_last) state_d = grp_full ? ST_READY : ST_PH1;
            ST_READY: state_d = ST_WAIT;
            ST_WAIT:  if (hread_done) state_d = rows_empty ? ST_DONE : ST_PH1;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_d)
            ST_PH1:           t_len = ph1_q;
            ST_PH2:           t_len = ph2_q;
            ST_GAP1, ST_GAP2: t_len = gap_q;
            default:          t_len = PH_W'(1);
        endcase
    end

    assign t_load     = (state_d != state_q);
    assign frame_load = (state_q == ST_IDLE) && frame_start;
    assign grp_start  = (state_d == ST_PH1) &&
                        ((state_q == ST_LOAD) || (state_q == ST_WAIT));
    assign row_xfer   = (state_d == ST_PH2) && (state_q == ST_GAP1);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign vclk1      = (state_q == ST_PH1);
    assign vclk2      = (state_q == ST_PH2);
    assign hpark      = (state_q == ST_PH1) || (state_q == ST_GAP1) ||
                        (state_q == ST_PH2) || (state_q == ST_GAP2);
    assign line_ready = (state_q == ST_READY);
    assign frame_done = (state_q == ST_DONE);
    assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/vbin_line_seq_chk.sv
module vbin_line_seq_chk #(
    parameter int BIN_W   = 4,
    parameter int BIN_MAX = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             hread_done,
    input logic             vclk1,
    input logic             vclk2,
    input logic             hpark,
    input logic             line_ready,
    input logic [BIN_W-1:0] grp_rows,
    input logic             busy,
    input logic             frame_done
);
    logic waiting_q;

    always_ff @(posedge clk) begin
        if (rst)             waiting_q <= 1'b0;
        else if (line_ready) waiting_q <= 1'b1;
        else if (hread_done) waiting_q <= 1'b0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!vclk1 && !vclk2 && !hpark && !line_ready)); // R1
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(vclk1 && vclk2)); // R3
    AST_GAP_AFTER_PH1: assert property (@(posedge clk) disable iff (rst)
        $fell(vclk1) |-> !vclk2); // R3
    AST_GAP_AFTER_PH2: assert property (@(posedge clk) disable iff (rst)
        $fell(vclk2) |-> !vclk1); // R3
    AST_PARK_HELD: assert property (@(posedge clk) disable iff (rst)
        (vclk1 || vclk2) |-> hpark); // R4
    AST_GROUP_RANGE: assert property (@(posedge clk) disable iff (rst)
        line_ready |-> (grp_rows != '0 && grp_rows <= BIN_W'(BIN_MAX))); // R5
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        line_ready |=> !line_ready); // R8
    AST_WAIT_STILL: assert property (@(posedge clk) disable iff (rst)
        waiting_q |-> (!vclk1 && !vclk2)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (!frame_done && !busy)); // R9
endmodule

bind vbin_line_seq vbin_line_seq_chk #(.BIN_W(BIN_W), .BIN_MAX(BIN_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hread_done (hread_done),
    .vclk1      (vclk1),
    .vclk2      (vclk2),
    .hpark      (hpark),
    .line_ready (line_ready),
    .grp_rows   (grp_rows),
    .busy       (busy),
    .frame_done (frame_done)
);

// File: tb/vbin_line_seq_tb.sv
`timescale 1ns/1ps
module vbin_line_seq_tb;
    localparam int ROW_W = 12;
    localparam int PH_W  = 8;
    localparam int BIN_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_start = 1'b0;
    logic [ROW_W-1:0] row_count = '0;
    logic [BIN_W-1:0] bin_factor = '0;
    logic [PH_W-1:0]  ph1_len = '0, ph2_len = '0, gap_len = '0;
    logic             hread_done = 1'b0;
    logic             vclk1, vclk2, hpark, line_ready, busy, frame_done;
    logic [BIN_W-1:0] grp_rows;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // monitor state
    int exp_p1 = 1, exp_p2 = 1, exp_gap = 1;
    int p1_run = 0, p2_run = 0, gap_cnt = 0, gap2_cnt = 0;
    logic prev1 = 0, prev2 = 0, after1 = 0, after2 = 0, waiting = 0;
    int bad_p1 = 0, bad_p2 = 0, bad_gap = 0, bad_gap2 = 0, bad_park = 0, bad_wait = 0;
    int rises = 0, ngrp = 0, fd_cnt = 0;
    int grp_seen [16];
    int grp_rep  [16];

    vbin_line_seq #(.ROW_W(ROW_W), .PH_W(PH_W), .BIN_MAX(8)) u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .row_count(row_count),
        .bin_factor(bin_factor), .ph1_len(ph1_len), .ph2_len(ph2_len),
        .gap_len(gap_len), .hread_done(hread_done), .vclk1(vclk1), .vclk2(vclk2),
        .hpark(hpark), .line_ready(line_ready), .grp_rows(grp_rows), .busy(busy),
        .frame_done(frame_done)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // edge monitor, samples at negedge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if ((vclk1 || vclk2) && !hpark) bad_park++;
            if (waiting && (vclk1 || vclk2)) bad_wait++;
            if (vclk1) p1_run++;
            if (prev1 && !vclk1) begin
                if (p1_run != exp_p1) bad_p1++;
                p1_run = 0; after1 = 1; gap_cnt = 0;
            end
            if (vclk2) p2_run++;
            if (!prev2 && vclk2) begin
                rises++;
                if (gap_cnt != exp_gap) bad_gap++;
                after1 = 0;
            end
            if (prev2 && !vclk2) begin
                if (p2_run != exp_p2) bad_p2++;
                p2_run = 0; after2 = 1; gap2_cnt = 0;
            end
            if (!prev1 && vclk1 && after2) begin
                if (gap2_cnt < exp_gap) bad_gap2++;
                after2 = 0;
            end
            if (!vclk1 && !vclk2) begin
                if (after1) gap_cnt++;
                if (after2) gap2_cnt++;
            end
            if (line_ready) begin
                if (ngrp < 16) begin
                    grp_seen[ngrp] = rises;
                    grp_rep[ngrp]  = int'(grp_rows);
                end
                ngrp++; rises = 0;
            end
            if (frame_done) fd_cnt++;
            prev1 = vclk1; prev2 = vclk2;
        end
    end

    // horizontal readout model: answers each line_ready after a few cycles
    always @(negedge clk) begin
        if (line_ready && !rst) begin
            waiting = 1;
            repeat (3) @(negedge clk);
            waiting = 0;
            hread_done = 1'b1;
            @(negedge clk);
            hread_done = 1'b0;
        end
    end

    // watchdog
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 vclk1", int'(vclk1), 0);
        check("R1 vclk2", int'(vclk2), 0);
        check("R1 hpark", int'(hpark), 0);
        check("R1 line_ready", int'(line_ready), 0);
        check("R1 frame_done", int'(frame_done), 0);
        check("R1 busy", int'(busy), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 still idle without start", int'(busy || vclk1 || vclk2), 0);
    endtask

    // runs one frame; mid_change alters inputs and restarts during the frame (R7)
    task automatic run_frame(input int rows, input int bin, input int l1, input int l2,
                             input int d, input bit mid_change, input string tag);
        int eb, ngexp, left, g, wd;
        eb = (bin == 0) ? 1 : ((bin > 8) ? 8 : bin);      // R6
        ngexp = (rows + eb - 1) / eb;
        @(posedge clk);
        exp_p1 = (l1 == 0) ? 1 : l1;
        exp_p2 = (l2 == 0) ? 1 : l2;
        exp_gap = (d == 0) ? 1 : d;
        p1_run = 0; p2_run = 0; after1 = 0; after2 = 0; rises = 0; ngrp = 0; fd_cnt = 0;
        bad_p1 = 0; bad_p2 = 0; bad_gap = 0; bad_gap2 = 0; bad_park = 0; bad_wait = 0;
        @(negedge clk);
        row_count = ROW_W'(rows); bin_factor = BIN_W'(bin);
        ph1_len = PH_W'(l1); ph2_len = PH_W'(l2); gap_len = PH_W'(d);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check({tag, " R10 no phase one cycle after start"}, int'(vclk1), 0);
        @(negedge clk);
        if (rows > 0) check({tag, " R10 vclk1 high two cycles after start"}, int'(vclk1), 1);
        else          check({tag, " R9 empty frame done two cycles after start"}, int'(frame_done), 1);
        if (mid_change) begin
            row_count = ROW_W'(9); bin_factor = BIN_W'(1);
            ph1_len = PH_W'(7); ph2_len = PH_W'(7); gap_len = PH_W'(5);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        wd = 0;
        while (fd_cnt == 0 && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        repeat (10) @(negedge clk);
        check({tag, " R9 frame_done pulses once"}, fd_cnt, 1);
        check({tag, " R9 group count"}, ngrp, ngexp);
        check({tag, " R9 busy released"}, int'(busy), 0);
        left = rows;
        for (int i = 0; i < ngexp && i < 16 && i < ngrp; i++) begin
            g = (left < eb) ? left : eb;
            check({tag, " R5 transfers in group"}, grp_seen[i], g);
            check({tag, " R5 grp_rows reported"}, grp_rep[i], g);
            left -= g;
        end
        check({tag, " R2 vclk1 width"}, bad_p1, 0);
        check({tag, " R2 vclk2 width"}, bad_p2, 0);
        check({tag, " R3 gap before vclk2"}, bad_gap, 0);
        check({tag, " R3 gap before vclk1"}, bad_gap2, 0);
        check({tag, " R4 park during transfer"}, bad_park, 0);
        check({tag, " R8 no transfer while waiting"}, bad_wait, 0);
    endtask

    initial begin
        test_reset();
        run_frame(3, 1, 3, 2, 1, 1'b0, "normal");
        run_frame(5, 2, 2, 2, 2, 1'b0, "bin2_short_tail");
        run_frame(2, 0, 0, 4, 0, 1'b0, "R6_zero_bin");
        run_frame(10, 12, 1, 1, 1, 1'b0, "R6_clamp");
        run_frame(8, 8, 2, 3, 1, 1'b0, "full8");
        run_frame(0, 3, 2, 2, 1, 1'b0, "empty");
        run_frame(4, 2, 2, 2, 1, 1'b1, "R7_mid_change");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule